// File: doc/BRIEF.md
# Half-Bridge Gate Enable Sequencer

This block converts two synchronous PWM commands into gate enables for the low and high switches of one half-bridge. The low-side command is active low and the high-side command is active high. One PWM net wired to both inputs therefore selects exactly one switch at a time. When both commands ask for conduction, or neither does, the block leaves both gates off. Neither side has priority over the other.

When the block hands conduction from one switch to the other, it holds both gates off for a programmable number of clock cycles. Those idle cycles are counted from the moment the previous switch actually turned off. If the commands were already apart by more than that window, the new switch turns on with no added delay. An active-low shutdown input and two supply-good flags gate the outputs. The low-supply flag gates both sides and the high-supply flag gates the high side only. Both gate paths share one register stage, so turn-on and turn-off latency is identical on the two sides.

Top module: `halfbridge_deadtime`

## Requirements
- R1: While `sd_n` is low, both `lo_gate` and `hi_gate` are low from the next clock edge on, whatever the commands are.
- R2: The low side is requested by `lo_cmd_n`=0 with `hi_cmd`=0. The high side is requested by `hi_cmd`=1 with `lo_cmd_n`=1.
- R3: With `lo_cmd_n`=0 and `hi_cmd`=1 (both asserted), both gates are low from the next edge.
- R4: With `lo_cmd_n`=1 and `hi_cmd`=0 (neither asserted), both gates are low from the next edge.
- R5: Between one gate being high and the opposite gate going high, both gates are low for at least N cycles. N is `dead_cycles` when it is nonzero and 1 when it is zero. The two gates are never high together.
- R6: When the commands switch sides directly, exactly N idle cycles separate the two gates. Idle cycles that have already elapsed count toward N.
- R7: If the gates have already been idle for N or more cycles, the opposite gate goes high one cycle after its command.
- R8: Every gate turns on and off exactly one cycle after the command change, on both sides.
- R9: With `dead_cycles`=0, exactly one idle cycle separates opposite gates.
- R10: While `lo_supply_ok` is low, both gates are low from the next edge.
- R11: While `hi_supply_ok` is low, `hi_gate` is low from the next edge and `lo_gate` still follows its command.
- R12: During reset both gates are low. The first turn-on after reset is not delayed.
- R13: A gate that re-enables on the same side it last drove does so one cycle after the command, shutdown release or supply recovery, without deadtime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lo_cmd_n | input | 1 | Low-side PWM command, active low |
| hi_cmd | input | 1 | High-side PWM command, active high |
| sd_n | input | 1 | Shutdown, active low |
| lo_supply_ok | input | 1 | Low-side supply good |
| hi_supply_ok | input | 1 | High-side supply good |
| dead_cycles | input | DT_W | Deadtime in clock cycles |
| lo_gate | output | 1 | Low-side gate enable |
| hi_gate | output | 1 | High-side gate enable |

## Verification
The embedded assertions check the following on every cycle:
- the gates are never high together;
- every opposite-side turn-on is preceded by enough idle cycles, measured by a run counter built only from the outputs;
- shutdown, supply loss and both conflicting command patterns force the gates low at the next edge.

Other behaviours need the directed scenarios:
- the exact idle length under synchronous, partly spaced and widely spaced edges;
- the one-cycle latency on both sides;
- immediate same-side recovery after shutdown or supply loss;
- the zero-deadtime case.

// File: rtl/halfbridge_deadtime.sv
module halfbridge_deadtime #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lo_cmd_n,
  input  logic            hi_cmd,
  input  logic            sd_n,
  input  logic            lo_supply_ok,
  input  logic            hi_supply_ok,
  input  logic [DT_W-1:0] dead_cycles,
  output logic            lo_gate,
  output logic            hi_gate
);
  localparam logic [1:0] SIDE_NONE = 2'd0;
  localparam logic [1:0] SIDE_LO   = 2'd1;
  localparam logic [1:0] SIDE_HI   = 2'd2;
  localparam logic [DT_W-1:0] ONE  = {{(DT_W-1){1'b0}}, 1'b1};

  logic [DT_W-1:0] idle_cnt;
  logic [DT_W-1:0] need;
  logic [1:0]      last_side;
  logic            want_lo, want_hi, lo_clear, hi_clear, lo_d, hi_d;

  assign want_lo  = !lo_cmd_n && !hi_cmd;
  assign want_hi  = lo_cmd_n && hi_cmd;
  assign need     = (dead_cycles == '0) ? ONE : dead_cycles;
  assign lo_clear = (last_side != SIDE_HI) || (idle_cnt >= need);
  assign hi_clear = (last_side != SIDE_LO) || (idle_cnt >= need);
  assign lo_d     = want_lo && lo_clear && sd_n && lo_supply_ok;
  assign hi_d     = want_hi && hi_clear && sd_n && lo_supply_ok && hi_supply_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_gate   <= 1'b0;
      hi_gate   <= 1'b0;
      idle_cnt  <= '0;
      last_side <= SIDE_NONE;
    end else begin
      lo_gate <= lo_d;
      hi_gate <= hi_d;
      if (lo_d || hi_d)
        idle_cnt <= '0;
      else if (idle_cnt != '1)
        idle_cnt <= idle_cnt + ONE;
      if (lo_d)
        last_side <= SIDE_LO;
      else if (hi_d)
        last_side <= SIDE_HI;
    end
  end

  logic [DT_W:0]   off_run;
  logic [1:0]      seen_side;
  logic [DT_W-1:0] dt_q;
  logic [DT_W:0]   req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_run   <= '0;
      seen_side <= SIDE_NONE;
      dt_q      <= '0;
    end else begin
      dt_q <= dead_cycles;
      if (lo_gate || hi_gate)
        off_run <= '0;
      else if (off_run != '1)
        off_run <= off_run + 1'b1;
      if (lo_gate)
        seen_side <= SIDE_LO;
      else if (hi_gate)
        seen_side <= SIDE_HI;
    end
  end

  assign req_q = (dt_q == '0) ? {{DT_W{1'b0}}, 1'b1} : {1'b0, dt_q};

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_gate && hi_gate));
  a_r5_deadtime_hi: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hi_gate) && seen_side == SIDE_LO) |-> off_run >= req_q);
  a_r5_deadtime_lo: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lo_gate) && seen_side == SIDE_HI) |-> off_run >= req_q);
  a_r1_shutdown_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_n |=> (!lo_gate && !hi_gate));
  a_r3_conflict_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_cmd_n && hi_cmd) |=> (!lo_gate && !hi_gate));
  a_r4_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_cmd_n && !hi_cmd) |=> (!lo_gate && !hi_gate));
  a_r10_lo_supply_off: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_supply_ok |=> (!lo_gate && !hi_gate));
  a_r11_hi_supply_off: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_supply_ok |=> !hi_gate);
endmodule

// File: tb/halfbridge_deadtime_tb.sv
`timescale 1ns/1ps
module halfbridge_deadtime_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, lo_cmd_n, hi_cmd, sd_n, lo_ok, hi_ok;
  logic [7:0] dead;
  logic       lo_gate, hi_gate;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2.5 clk = ~clk;

  halfbridge_deadtime #(.DT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .lo_cmd_n(lo_cmd_n), .hi_cmd(hi_cmd), .sd_n(sd_n),
    .lo_supply_ok(lo_ok), .hi_supply_ok(hi_ok), .dead_cycles(dead),
    .lo_gate(lo_gate), .hi_gate(hi_gate));

  task automatic chk(input string req, input logic exp_lo, input logic exp_hi);
    n_chk++;
    if (lo_gate !== exp_lo || hi_gate !== exp_hi) begin
      n_bad++;
      $display("FAIL %s: lo/hi actual %b%b expected %b%b", req, lo_gate, hi_gate, exp_lo, exp_hi);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic cmd_lo();   lo_cmd_n = 1'b0; hi_cmd = 1'b0; endtask
  task automatic cmd_hi();   lo_cmd_n = 1'b1; hi_cmd = 1'b1; endtask
  task automatic cmd_none(); lo_cmd_n = 1'b1; hi_cmd = 1'b0; endtask

  task automatic t_reset();
    rst_n = 1'b0; sd_n = 1'b1; lo_ok = 1'b1; hi_ok = 1'b1; dead = 8'd3;
    cmd_lo();
    step(); step();
    chk("R12 reset low", 1'b0, 1'b0);
    cmd_none();
    rst_n = 1'b1;
    step();
    chk("R4 neither after reset", 1'b0, 1'b0);
  endtask

  task automatic t_first_on();
    cmd_lo(); step();
    chk("R12 R2 R8 first low-side on", 1'b1, 1'b0);
  endtask

  task automatic t_shared_edge();
    cmd_hi();
    for (int i = 0; i < 3; i++) begin step(); chk("R5 R6 idle during deadtime", 1'b0, 1'b0); end
    step(); chk("R5 R2 high side after 3 idle cycles", 1'b0, 1'b1);
  endtask

  task automatic t_direct();
    cmd_none(); step();
    chk("R8 R4 high-side off latency", 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step();
    chk("R4 stays off with no request", 1'b0, 1'b0);
    cmd_lo(); step();
    chk("R7 direct drive no extra delay", 1'b1, 1'b0);
  endtask

  task automatic t_window();
    cmd_none(); step();
    chk("R8 low-side off latency", 1'b0, 1'b0);
    cmd_hi(); step();
    chk("R6 partial window idle 2", 1'b0, 1'b0);
    step(); chk("R6 partial window idle 3", 1'b0, 1'b0);
    step(); chk("R6 high side after remaining window", 1'b0, 1'b1);
  endtask

  task automatic t_conflict();
    lo_cmd_n = 1'b0; hi_cmd = 1'b1;
    for (int i = 0; i < 3; i++) begin step(); chk("R3 both asserted off", 1'b0, 1'b0); end
    cmd_hi(); step();
    chk("R13 same side resumes immediately", 1'b0, 1'b1);
  endtask

  task automatic t_dead_zero();
    dead = 8'd0;
    cmd_lo(); step();
    chk("R9 one idle cycle", 1'b0, 1'b0);
    step(); chk("R9 low side after single idle", 1'b1, 1'b0);
    dead = 8'd3;
  endtask

  task automatic t_shutdown();
    sd_n = 1'b0; step();
    chk("R1 shutdown forces off", 1'b0, 1'b0);
    cmd_hi(); step();
    chk("R1 shutdown ignores high request", 1'b0, 1'b0);
    cmd_lo(); step();
    chk("R1 shutdown ignores low request", 1'b0, 1'b0);
    sd_n = 1'b1; step();
    chk("R13 release resumes same side", 1'b1, 1'b0);
  endtask

  task automatic t_lo_supply();
    lo_ok = 1'b0; step();
    chk("R10 low supply bad forces off", 1'b0, 1'b0);
    cmd_hi();
    for (int i = 0; i < 4; i++) begin step(); chk("R10 high side held off", 1'b0, 1'b0); end
    lo_ok = 1'b1; step();
    chk("R7 high after long idle", 1'b0, 1'b1);
  endtask

  task automatic t_hi_supply();
    hi_ok = 1'b0; step();
    chk("R11 high supply bad drops high side", 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step();
    cmd_lo(); step();
    chk("R11 low side still follows command", 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin step(); chk("R11 low side unaffected", 1'b1, 1'b0); end
    hi_ok = 1'b1;
  endtask

  initial begin
    t_reset();
    t_first_on();
    t_shared_edge();
    t_direct();
    t_window();
    t_conflict();
    t_dead_zero();
    t_shutdown();
    t_lo_supply();
    t_hi_supply();
    step();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule